// File: doc/BRIEF.md
# Event Counter Bank with Global Control

This block is a bank of event counters for performance monitoring. It holds two general-purpose counters and three fixed-function counters, each 40 bits wide. Each cycle, every counter may receive an event pulse, and the counter adds one to its value only when two enables agree: its bit in the global enable register, and a privilege enable that matches the current mode (kernel or user). General-purpose counters take events that have already been selected, plus a two-bit privilege code on an input pin. Fixed counters take their privilege code from a control register.

When a counter wraps from all ones to zero, its bit in the overflow status register is set on that same clock edge. The bit stays set until software writes a 1 to the matching position of the overflow-clear register. A single interrupt line is high while any set status bit has its interrupt enabled. A small register port reads and writes the control registers, the status register and the counter values. Software can preload any counter through this port.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset, every counter, both control registers, every overflow status bit and `irq` are zero.
- R2: Fixed counter j takes its control from the 4-bit field at bits 4j+3..4j of the fixed control register (address 0). The field's low two bits are a privilege code: 0 never counts, 1 counts only in kernel mode (`priv_user`=0), 2 counts only in user mode (`priv_user`=1), and 3 counts in both modes.
- R3: In the global enable register (address 1), bit i enables general-purpose counter i and bit 32+j enables fixed counter j. An event is counted only when both the global enable bit and the privilege enable are true.
- R4: General-purpose counter i uses `gp_mode[2i+1:2i]` as its privilege code, with the same encoding as in R2.
- R5: A 40-bit counter that counts while at all ones becomes zero, and its overflow status bit is set on that same clock edge. A counter with no count and no preload holds its value.
- R6: The overflow status register (address 2) shows general-purpose counter i at bit i and fixed counter j at bit 32+j. A write to this address has no effect. A set status bit stays set until it is cleared as R7 describes.
- R7: A write to the overflow-clear register (address 3) clears every status bit whose position holds a 1 in the written data. Positions written 0 keep their status. This address reads as zero.
- R8: If a clear and a new overflow of the same counter fall in the same cycle, the status bit is set after that edge.
- R9: `irq` is high while any status bit is set whose interrupt is enabled. For fixed counter j, the interrupt enable is bit 4j+3 of the fixed control register. For general-purpose counter i, it is input `gp_irq_en[i]`.
- R10: Reserved bits read as zero and ignore writes. These are bit 4j+2 of each fixed field, bits 12 and up of the fixed control register, and every bit of the global enable register outside 0..1 and 32..34.
- R11: Counter values read and write at address 4+i for general-purpose counter i and at address 6+j for fixed counter j, in the low 40 bits. A write preloads the counter. A preload wins over an event in the same cycle, and a preload never sets the overflow status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` |
| priv_user | input | 1 | Current mode: 0 kernel, 1 user |
| gp_evt | input | 2 | Event pulses for the general-purpose counters |
| gp_mode | input | 4 | Privilege codes for the general-purpose counters |
| gp_irq_en | input | 2 | Interrupt enables for the general-purpose counters |
| fix_evt | input | 3 | Event pulses for the fixed counters |
| gp_count | output | 80 | General-purpose counter values, counter i at bits 40i+39..40i |
| fix_count | output | 120 | Fixed counter values, counter j at bits 40j+39..40j |
| ovf_status | output | 64 | Overflow status register |
| irq | output | 1 | Overflow interrupt |

## Verification
Two sets of functions can land on the same clock edge. The first pair is a software clear and a wrap of the same counter. The bench preloads a fixed counter to all ones, sets its status bit with one wrap, preloads it to all ones again, and then sends an event in the same cycle as a clear write for that bit. After that edge, the status bit and the interrupt must still be high. The second case is a preload and an event arriving together: the counter must hold the written value, not that value plus one. The privilege, enable and interrupt behaviour is swept over every code, mode and counter, and each expected value is worked out from the encoding.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int REG_W        = 64;
  localparam int FIX_BIT_BASE = 32;

  localparam int A_FIXCTRL  = 0;
  localparam int A_GLBEN    = 1;
  localparam int A_OVFSTAT  = 2;
  localparam int A_OVFCLR   = 3;
  localparam int A_CNT_BASE = 4;

  typedef enum logic [1:0] {
    EN_OFF  = 2'd0,
    EN_KERN = 2'd1,
    EN_USER = 2'd2,
    EN_ALL  = 2'd3
  } en_code_e;

  function automatic logic priv_ok(input logic [1:0] code, input logic user);
    return user ? code[1] : code[0];
  endfunction
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = inc | load;
    wrap   = inc & ~load & (&cnt_q);
    cnt_d  = load ? load_val : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load) |=> $stable(cnt_q));
  p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));
  p_preload_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/evt_ctrl_regs.sv
module evt_ctrl_regs
  import evt_pkg::*;
#(
  parameter int NUM_GP  = 2,
  parameter int NUM_FIX = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_fix,
  input  logic             we_glb,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] fix_ctrl,
  output logic [REG_W-1:0] glb_en
);
  function automatic logic [REG_W-1:0] fix_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int j = 0; j < NUM_FIX; j++) begin
      m[4*j]   = 1'b1;
      m[4*j+1] = 1'b1;
      m[4*j+3] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [REG_W-1:0] glb_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_GP; i++) m[i] = 1'b1;
    for (int j = 0; j < NUM_FIX; j++) m[FIX_BIT_BASE+j] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] FIX_MASK = fix_mask();
  localparam logic [REG_W-1:0] GLB_MASK = glb_mask();

  logic [REG_W-1:0] fix_q, fix_d;
  logic [REG_W-1:0] glb_q, glb_d;

  always_comb begin
    fix_d = wdata & FIX_MASK;
    glb_d = wdata & GLB_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fix_q <= '0;
      glb_q <= '0;
    end else begin
      if (we_fix) fix_q <= fix_d;
      if (we_glb) glb_q <= glb_d;
    end
  end

  assign fix_ctrl = fix_q;
  assign glb_en   = glb_q;

  p_fix_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_fix |=> $stable(fix_q));
  p_glb_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_glb |=> $stable(glb_q));
endmodule

// File: rtl/evt_ovf_status.sv
module evt_ovf_status
  import evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] ovf_evt,
  input  logic             clr_we,
  input  logic [REG_W-1:0] clr_data,
  input  logic [REG_W-1:0] irq_mask,
  output logic [REG_W-1:0] status,
  output logic             irq
);
  logic [REG_W-1:0] stat_q, stat_d, clr_bits;

  always_comb begin
    clr_bits = clr_we ? clr_data : '0;
    stat_d   = ovf_evt | (stat_q & ~clr_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign status = stat_q;
  assign irq    = |(stat_q & irq_mask);

  p_ovf_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt != '0) |=> ((stat_q & $past(ovf_evt)) == $past(ovf_evt)));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((stat_q & $past(clr_data) & ~$past(ovf_evt)) == '0));
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == '0) |-> !irq);
endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
  import evt_pkg::*;
#(
  parameter int NUM_GP  = 2,
  parameter int NUM_FIX = 3,
  parameter int CNT_W   = 40,
  parameter int ADDR_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [REG_W-1:0]         reg_wdata,
  output logic [REG_W-1:0]         reg_rdata,
  input  logic                     priv_user,
  input  logic [NUM_GP-1:0]        gp_evt,
  input  logic [2*NUM_GP-1:0]      gp_mode,
  input  logic [NUM_GP-1:0]        gp_irq_en,
  input  logic [NUM_FIX-1:0]       fix_evt,
  output logic [NUM_GP*CNT_W-1:0]  gp_count,
  output logic [NUM_FIX*CNT_W-1:0] fix_count,
  output logic [REG_W-1:0]         ovf_status,
  output logic                     irq
);
  localparam int A_FIX_BASE = A_CNT_BASE + NUM_GP;

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [REG_W-1:0] fix_ctrl, glb_en, irq_mask, ovf_evt;
  logic             we_fix, we_glb, we_clr;
  logic [NUM_GP-1:0]  gp_inc, gp_load, gp_wrap;
  logic [NUM_FIX-1:0] fx_inc, fx_load, fx_wrap;

  always_comb begin
    we_fix = reg_we && (int'(reg_addr) == A_FIXCTRL);
    we_glb = reg_we && (int'(reg_addr) == A_GLBEN);
    we_clr = reg_we && (int'(reg_addr) == A_OVFCLR);
  end

  evt_ctrl_regs #(.NUM_GP(NUM_GP), .NUM_FIX(NUM_FIX)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .we_fix(we_fix), .we_glb(we_glb),
    .wdata(reg_wdata), .fix_ctrl(fix_ctrl), .glb_en(glb_en)
  );

  for (genvar i = 0; i < NUM_GP; i++) begin : g_gp
    always_comb begin
      gp_inc[i]  = gp_evt[i] & glb_en[i] & priv_ok(gp_mode[2*i +: 2], priv_user);
      gp_load[i] = reg_we && (int'(reg_addr) == A_CNT_BASE + i);
    end
    evt_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n_s), .inc(gp_inc[i]), .load(gp_load[i]),
      .load_val(reg_wdata[CNT_W-1:0]), .cnt(gp_count[i*CNT_W +: CNT_W]),
      .wrap(gp_wrap[i])
    );
  end

  for (genvar j = 0; j < NUM_FIX; j++) begin : g_fix
    always_comb begin
      fx_inc[j]  = fix_evt[j] & glb_en[FIX_BIT_BASE+j] &
                   priv_ok(fix_ctrl[4*j +: 2], priv_user);
      fx_load[j] = reg_we && (int'(reg_addr) == A_FIX_BASE + j);
    end
    evt_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n_s), .inc(fx_inc[j]), .load(fx_load[j]),
      .load_val(reg_wdata[CNT_W-1:0]), .cnt(fix_count[j*CNT_W +: CNT_W]),
      .wrap(fx_wrap[j])
    );
  end

  always_comb begin
    ovf_evt  = '0;
    irq_mask = '0;
    for (int i = 0; i < NUM_GP; i++) begin
      ovf_evt[i]  = gp_wrap[i];
      irq_mask[i] = gp_irq_en[i];
    end
    for (int j = 0; j < NUM_FIX; j++) begin
      ovf_evt[FIX_BIT_BASE+j]  = fx_wrap[j];
      irq_mask[FIX_BIT_BASE+j] = fix_ctrl[4*j+3];
    end
  end

  evt_ovf_status u_stat (
    .clk(clk), .rst_n(rst_n_s), .ovf_evt(ovf_evt), .clr_we(we_clr),
    .clr_data(reg_wdata), .irq_mask(irq_mask), .status(ovf_status), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (int'(reg_addr) == A_FIXCTRL) reg_rdata = fix_ctrl;
    if (int'(reg_addr) == A_GLBEN)   reg_rdata = glb_en;
    if (int'(reg_addr) == A_OVFSTAT) reg_rdata = ovf_status;
    for (int i = 0; i < NUM_GP; i++)
      if (int'(reg_addr) == A_CNT_BASE + i)
        reg_rdata = REG_W'(gp_count[i*CNT_W +: CNT_W]);
    for (int j = 0; j < NUM_FIX; j++)
      if (int'(reg_addr) == A_FIX_BASE + j)
        reg_rdata = REG_W'(fix_count[j*CNT_W +: CNT_W]);
  end

  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq |-> ((ovf_status & irq_mask) != '0));
  p_gated_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!glb_en[0] && !gp_load[0]) |=> $stable(gp_count[CNT_W-1:0]));
endmodule

// File: tb/evt_ctr_bank_tb.sv
module evt_ctr_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 40;
  localparam logic [CW-1:0] ONES = {CW{1'b1}};

  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_we;
  logic [3:0]   reg_addr;
  logic [63:0]  reg_wdata;
  logic [63:0]  reg_rdata;
  logic         priv_user;
  logic [1:0]   gp_evt;
  logic [3:0]   gp_mode;
  logic [1:0]   gp_irq_en;
  logic [2:0]   fix_evt;
  logic [79:0]  gp_count;
  logic [119:0] fix_count;
  logic [63:0]  ovf_status;
  logic         irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_ctr_bank u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .priv_user(priv_user),
    .gp_evt(gp_evt), .gp_mode(gp_mode), .gp_irq_en(gp_irq_en),
    .fix_evt(fix_evt), .gp_count(gp_count), .fix_count(fix_count),
    .ovf_status(ovf_status), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle of stimulus: drive at a falling edge, release at the next one.
  task automatic step(input logic we, input logic [3:0] a, input logic [63:0] d,
                      input logic [1:0] ge, input logic [2:0] fe);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; gp_evt = ge; fix_evt = fe;
    @(negedge clk);
    reg_we = 1'b0; gp_evt = '0; fix_evt = '0;
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    step(1'b1, a, d, 2'b00, 3'b000);
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic pe(input logic [1:0] code, input logic user);
    return user ? code[1] : code[0];
  endfunction

  logic [63:0] r;

  initial begin
    #(200000*CLK_PERIOD);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    priv_user = 1'b0; gp_evt = '0; gp_mode = '0; gp_irq_en = '0; fix_evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;

    // R1 reset state
    check("R1 gp_count", 64'(gp_count[39:0] | gp_count[79:40]), 64'd0);
    check("R1 fix_count", 64'(fix_count[39:0] | fix_count[79:40] | fix_count[119:80]), 64'd0);
    check("R1 status", ovf_status, 64'd0);
    check("R1 irq", 64'(irq), 64'd0);
    rd(4'd0, r); check("R1 fixctrl", r, 64'd0);
    rd(4'd1, r); check("R1 glben", r, 64'd0);

    // R2 fixed privilege sweep
    wr(4'd1, 64'h0000_0007_0000_0000);
    for (int j = 0; j < 3; j++)
      for (int c = 0; c < 4; c++)
        for (int u = 0; u < 2; u++) begin
          wr(4'd0, 64'(c) << (4*j));
          wr(4'(6+j), 64'd0);
          priv_user = u[0];
          step(1'b0, 4'd0, 64'd0, 2'b00, 3'(1 << j));
          check($sformatf("R2 fix%0d code%0d user%0d", j, c, u),
                64'(fix_count[j*CW +: CW]), 64'(pe(2'(c), u[0])));
        end

    // R3 global enable gating
    priv_user = 1'b0;
    wr(4'd0, 64'h333);
    for (int j = 0; j < 3; j++) wr(4'(6+j), 64'd0);
    wr(4'd1, 64'h0000_0002_0000_0000);
    step(1'b0, 4'd0, 64'd0, 2'b00, 3'b111);
    check("R3 fix0 off", 64'(fix_count[39:0]), 64'd0);
    check("R3 fix1 on", 64'(fix_count[79:40]), 64'd1);
    check("R3 fix2 off", 64'(fix_count[119:80]), 64'd0);
    wr(4'd1, 64'd0);
    step(1'b0, 4'd0, 64'd0, 2'b00, 3'b111);
    check("R3 all off", 64'(fix_count[79:40]), 64'd1);

    // R4 general-purpose privilege sweep
    wr(4'd1, 64'h3);
    for (int i = 0; i < 2; i++)
      for (int c = 0; c < 4; c++)
        for (int u = 0; u < 2; u++) begin
          wr(4'(4+i), 64'd0);
          gp_mode = 4'(c) << (2*i);
          priv_user = u[0];
          step(1'b0, 4'd0, 64'd0, 2'(1 << i), 3'b000);
          check($sformatf("R4 gp%0d code%0d user%0d", i, c, u),
                64'(gp_count[i*CW +: CW]), 64'(pe(2'(c), u[0])));
        end

    // R5 wrap and R9 fixed interrupt, R6 read and write-ignore
    priv_user = 1'b0;
    wr(4'd0, 64'h00B);
    wr(4'd1, 64'h0000_0001_0000_0000);
    wr(4'd6, 64'(ONES));
    check("R11 preload no ovf", ovf_status, 64'd0);
    step(1'b0, 4'd0, 64'd0, 2'b00, 3'b001);
    check("R5 wrap value", 64'(fix_count[39:0]), 64'd0);
    check("R5 ovf same edge", ovf_status, 64'h0000_0001_0000_0000);
    check("R9 fixed irq", 64'(irq), 64'd1);
    rd(4'd2, r); check("R6 status read", r, 64'h0000_0001_0000_0000);
    wr(4'd2, 64'd0);
    check("R6 write ignored", ovf_status, 64'h0000_0001_0000_0000);
    step(1'b0, 4'd0, 64'd0, 2'b00, 3'b000);
    check("R6 sticky", ovf_status, 64'h0000_0001_0000_0000);

    // R7 clear
    rd(4'd3, r); check("R7 clear reads zero", r, 64'd0);
    wr(4'd3, 64'h0000_0006_0000_0003);
    check("R7 zero bit keeps", ovf_status, 64'h0000_0001_0000_0000);
    wr(4'd3, 64'h0000_0001_0000_0000);
    check("R7 cleared", ovf_status, 64'd0);
    check("R7 irq low", 64'(irq), 64'd0);

    // R8 clear and overflow together
    wr(4'd6, 64'(ONES));
    step(1'b0, 4'd0, 64'd0, 2'b00, 3'b001);
    wr(4'd6, 64'(ONES));
    step(1'b1, 4'd3, 64'h0000_0001_0000_0000, 2'b00, 3'b001);
    check("R8 ovf wins", ovf_status, 64'h0000_0001_0000_0000);
    check("R8 irq stays", 64'(irq), 64'd1);
    wr(4'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R7 clear all", ovf_status, 64'd0);

    // R9 general-purpose interrupt enable
    wr(4'd1, 64'h1);
    gp_mode = 4'b0011; gp_irq_en = 2'b00;
    wr(4'd4, 64'(ONES));
    step(1'b0, 4'd0, 64'd0, 2'b01, 3'b000);
    check("R5 gp wrap status", ovf_status, 64'h1);
    check("R9 gp irq masked", 64'(irq), 64'd0);
    gp_irq_en = 2'b01; #1;
    check("R9 gp irq enabled", 64'(irq), 64'd1);
    wr(4'd3, 64'h1);
    check("R9 gp irq cleared", 64'(irq), 64'd0);

    // R10 reserved bits
    wr(4'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(4'd0, r); check("R10 fixctrl", r, 64'h0000_0000_0000_0BBB);
    wr(4'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(4'd1, r); check("R10 glben", r, 64'h0000_0007_0000_0003);

    // R11 preload wins over event, read-back
    gp_mode = 4'b1111;
    step(1'b1, 4'd5, 64'hFFFF_FF00_0000_0064, 2'b10, 3'b000);
    check("R11 preload wins", 64'(gp_count[79:40]), 64'h64);
    rd(4'd5, r); check("R11 read gp1", r, 64'h0000_0000_0000_0064);
    wr(4'd8, 64'h12_3456_789A);
    rd(4'd8, r); check("R11 read fix2", r, 64'h0000_0012_3456_789A);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule